// File: doc/BRIEF.md
# Multi-Mode Timer/Event Counter Core

This block is a 16-bit timer and event counter. An 8-bit control register selects one of seven counting modes and the count source, and it carries a self-clearing software trigger bit. A small write port also loads a run bit, a period compare value and a duty compare value. The core drives one output pin and a capture register. Depending on the mode, the pin toggles, produces a pulse-width modulated waveform, or produces a single pulse.

The count source is either the internal prescaled tick (`tick_in`) or a rising edge of the asynchronous event input (`evt_in`). The event input passes through a two-flop synchronizer and an edge detector first. Event-count mode always uses the event input, whatever the source-select bit holds. Pulse-width measurement mode counts ticks and uses event edges to capture and restart. The mode and source bits are locked while the timer runs. A write that tries to change them is dropped and sets a sticky error flag.

Top module: `mtimer_core`

## Requirements
- R1: After reset the control readback is 00h, the run bit is 0, the counter and the capture register are 0, the output is low and the error flag is clear. The period register starts at FFFFh and the duty register at 0.
- R2: Control register layout is mode in bits [2:0], source select in bit 5 and software trigger in bit 6. Bits 3, 4, 6 and 7 always read 0, so a write of FFh reads back as 27h.
- R3: While the run bit is 1, a control write whose mode or source-select bits differ from the stored ones is ignored and sets a sticky error flag. A write of the same mode and source bits is accepted and leaves the flag unchanged.
- R4: With source select 0 the counter advances on `tick_in`. With source select 1 it advances once per rising edge of `evt_in`, which takes effect 3 clocks after the edge is sampled. Mode 001 always counts `evt_in` edges, even with source select 0.
- R5: In modes 000 (interval) and 001 (event count), each count step takes the counter from 0 up to the period value and then back to 0. The output toggles on each wrap.
- R6: In mode 100 (PWM) the counter cycles from 0 to the period value, and the output is high exactly while the counter is below the duty value.
- R7: In mode 011 (one-shot), a trigger clears the counter and runs a single pass from 0 to the period value, with the output high while the counter is below the duty value. The counter then rests at 0. In mode 010 (triggered PWM), a trigger starts a repeating PWM pass, and a new trigger restarts it at 0.
- R8: A software trigger has no effect in modes other than 010 and 011, or while the run bit is 0. Modes 010 and 011 hold the counter at 0 until triggered.
- R9: In mode 101 (free-running) the counter wraps from FFFFh to 0 on a count step, and the output toggles on each wrap.
- R10: In mode 110 (pulse width), the counter counts ticks. Each detected `evt_in` edge copies the counter into the capture register, clears the counter and toggles the output. With edges N clocks apart and a tick every clock, the capture value is N-1.
- R11: In mode 111 the counter is held at 0 and the output is low.
- R12: While the run bit is 0 the counter is held at 0, the output is low and any one-shot or triggered pass is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 run bit, 2 period, 3 duty |
| wr_data | input | 16 | Write data |
| tick_in | input | 1 | Internal prescaled count enable |
| evt_in | input | 1 | Asynchronous external event input |
| ctrl_rd | output | 8 | Control register readback |
| run_o | output | 1 | Run bit |
| count_o | output | 16 | Counter value |
| capture_o | output | 16 | Pulse-width capture value |
| tmr_out | output | 1 | Timer output pin |
| cfg_err | output | 1 | Sticky locked-configuration error |

## Verification
The assertions check several rules on every cycle: the reserved and trigger bits read 0, the configuration lock and the stickiness of its error flag hold, the counter stays frozen in event-count mode when no synchronized edge arrives, and the counter is held at 0 with the output low when stopped or in the prohibited mode. The waveform shapes need the bench's scenarios, because they depend on the period and duty values and on trigger history: toggle spacing, PWM duty, the length of a one-shot pass, retriggering, the free-running wrap and the capture values. The bench's cycle-level model shows these by comparing all outputs on every clock.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  typedef enum logic [2:0] {
    TM_INTERVAL  = 3'd0,
    TM_EVCOUNT   = 3'd1,
    TM_XTRIG_PWM = 3'd2,
    TM_ONESHOT   = 3'd3,
    TM_PWM       = 3'd4,
    TM_FREERUN   = 3'd5,
    TM_PWIDTH    = 3'd6,
    TM_BAD       = 3'd7
  } tmode_e;

  // control register bit positions
  localparam int EVSEL_BIT = 5;
  localparam int TRIG_BIT  = 6;

  // write port addresses
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_RUN  = 2'd1;
  localparam logic [1:0] A_PER  = 2'd2;
  localparam logic [1:0] A_DUTY = 2'd3;

  // modes in which a software trigger is meaningful
  function automatic logic trig_mode(input tmode_e m);
    return (m == TM_XTRIG_PWM) || (m == TM_ONESHOT);
  endfunction

  // event-count mode forces the external source; width mode counts ticks
  function automatic logic uses_ext(input tmode_e m, input logic evsel);
    return (m == TM_EVCOUNT) || (evsel && (m != TM_PWIDTH));
  endfunction

endpackage

// File: rtl/mtimer_evsync.sv
module mtimer_evsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_o
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_in};
  end

  // last synchronizer stage high, extra history flop low
  assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/mtimer_ctrl.sv
module mtimer_ctrl
  import mtimer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output tmode_e        mode_o,
  output logic          evsel_o,
  output logic          run_o,
  output logic [CW-1:0] per_o,
  output logic [CW-1:0] duty_o,
  output logic          trig_o,
  output logic          cfg_err_o,
  output logic [7:0]    ctrl_rd_o
);

  tmode_e mode_q;
  logic   evsel_q, run_q, err_q;
  logic [CW-1:0] per_q, duty_q;

  logic   ctrl_wr, cfg_same, cfg_ok;
  tmode_e new_mode;

  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign new_mode = tmode_e'(wr_data[2:0]);
  assign cfg_same = (new_mode == mode_q) && (wr_data[EVSEL_BIT] == evsel_q);
  assign cfg_ok   = !run_q || cfg_same;
  assign trig_o   = ctrl_wr && wr_data[TRIG_BIT] && run_q && trig_mode(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= TM_INTERVAL;
      evsel_q <= 1'b0;
      run_q   <= 1'b0;
      err_q   <= 1'b0;
      per_q   <= '1;
      duty_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          if (cfg_ok) begin
            mode_q  <= new_mode;
            evsel_q <= wr_data[EVSEL_BIT];
          end else begin
            err_q <= 1'b1;
          end
        end
        A_RUN:   run_q  <= wr_data[0];
        A_PER:   per_q  <= wr_data;
        default: duty_q <= wr_data;
      endcase
    end
  end

  always_comb begin
    ctrl_rd_o            = '0;
    ctrl_rd_o[2:0]       = mode_q;
    ctrl_rd_o[EVSEL_BIT] = evsel_q;
  end

  assign mode_o    = mode_q;
  assign evsel_o   = evsel_q;
  assign run_o     = run_q;
  assign per_o     = per_q;
  assign duty_o    = duty_q;
  assign cfg_err_o = err_q;

endmodule

// File: rtl/mtimer_count.sv
module mtimer_count
  import mtimer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmode_e        mode_i,
  input  logic          run_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] duty_i,
  input  logic          trig_i,
  input  logic          cnt_step_i,
  input  logic          evt_step_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cap_o,
  output logic          out_o
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q, cap_q;
  logic          tgl_q, act_q;

  function automatic logic at_top(input logic [CW-1:0] c, input logic [CW-1:0] p);
    return c >= p;
  endfunction

  function automatic logic [CW-1:0] wrap_inc(input logic [CW-1:0] c, input logic [CW-1:0] p);
    return at_top(c, p) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
      tgl_q <= 1'b0;
      act_q <= 1'b0;
    end else if (!run_i || (mode_i == TM_BAD)) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      case (mode_i)
        TM_INTERVAL, TM_EVCOUNT: begin
          if (cnt_step_i) begin
            cnt_q <= wrap_inc(cnt_q, per_i);
            if (at_top(cnt_q, per_i)) tgl_q <= ~tgl_q;
          end
        end
        TM_XTRIG_PWM, TM_ONESHOT: begin
          if (trig_i) begin
            act_q <= 1'b1;
            cnt_q <= '0;
          end else if (act_q && cnt_step_i) begin
            cnt_q <= wrap_inc(cnt_q, per_i);
            if (at_top(cnt_q, per_i) && (mode_i == TM_ONESHOT)) act_q <= 1'b0;
          end
        end
        TM_PWM: begin
          if (cnt_step_i) cnt_q <= wrap_inc(cnt_q, per_i);
        end
        TM_FREERUN: begin
          if (cnt_step_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_MAX) tgl_q <= ~tgl_q;
          end
        end
        TM_PWIDTH: begin
          if (evt_step_i) begin
            cap_q <= cnt_q;
            cnt_q <= '0;
            tgl_q <= ~tgl_q;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (mode_i)
      TM_INTERVAL, TM_EVCOUNT, TM_FREERUN, TM_PWIDTH: out_o = tgl_q;
      TM_XTRIG_PWM, TM_ONESHOT:                       out_o = act_q && (cnt_q < duty_i);
      TM_PWM:                                         out_o = cnt_q < duty_i;
      default:                                        out_o = 1'b0;
    endcase
    if (!run_i) out_o = 1'b0;
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;

endmodule

// File: rtl/mtimer_core.sv
module mtimer_core
  import mtimer_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          tick_in,
  input  logic          evt_in,
  output logic [7:0]    ctrl_rd,
  output logic          run_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] capture_o,
  output logic          tmr_out,
  output logic          cfg_err
);

  // named internal events, also observed by the checker
  tmode_e        mode;
  logic          evsel, trig_fire, evt_step, cnt_step;
  logic [CW-1:0] per, duty;

  mtimer_evsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (evt_in),
    .edge_o   (evt_step)
  );

  mtimer_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mode_o    (mode),
    .evsel_o   (evsel),
    .run_o     (run_o),
    .per_o     (per),
    .duty_o    (duty),
    .trig_o    (trig_fire),
    .cfg_err_o (cfg_err),
    .ctrl_rd_o (ctrl_rd)
  );

  assign cnt_step = uses_ext(mode, evsel) ? evt_step : tick_in;

  mtimer_count #(.CW(CW)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .run_i      (run_o),
    .per_i      (per),
    .duty_i     (duty),
    .trig_i     (trig_fire),
    .cnt_step_i (cnt_step),
    .evt_step_i (evt_step),
    .tick_i     (tick_in),
    .cnt_o      (count_o),
    .cap_o      (capture_o),
    .out_o      (tmr_out)
  );

endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [2:0]    wr_mode,
  input logic          wr_evsel,
  input logic [7:0]    ctrl_rd,
  input logic          run_o,
  input logic [CW-1:0] count_o,
  input logic          tmr_out,
  input logic          cfg_err,
  input logic          evt_step
);

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[7:6] == 2'b00) && (ctrl_rd[4:3] == 2'b00));

  assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && wr_en && (wr_addr == 2'd0) &&
     ((wr_mode != ctrl_rd[2:0]) || (wr_evsel != ctrl_rd[5])))
    |=> cfg_err && (ctrl_rd[5:0] == $past(ctrl_rd[5:0])));

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_evt_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && (ctrl_rd[2:0] == 3'd1) && !evt_step && !(wr_en && (wr_addr == 2'd1)))
    |=> $stable(count_o));

  assert_bad_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[2:0] == 3'd7) |=> (count_o == '0));

  assert_bad_mode_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[2:0] == 3'd7) |-> !tmr_out);

  assert_stop_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |=> (count_o == '0));

  assert_stop_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> !tmr_out);

endmodule

bind mtimer_core mtimer_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_mode  (wr_data[2:0]),
  .wr_evsel (wr_data[5]),
  .ctrl_rd  (ctrl_rd),
  .run_o    (run_o),
  .count_o  (count_o),
  .tmr_out  (tmr_out),
  .cfg_err  (cfg_err),
  .evt_step (evt_step)
);

// File: tb/sim_mtimer_core.sv
`timescale 1ns/1ps
module sim_mtimer_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        tick_in = 1'b0;
  logic        evt_in;
  logic [7:0]  ctrl_rd;
  logic        run_o, tmr_out, cfg_err;
  logic [15:0] count_o, capture_o;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int tcnt = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  mtimer_core u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_in(tick_in), .evt_in(evt_in), .ctrl_rd(ctrl_rd), .run_o(run_o),
    .count_o(count_o), .capture_o(capture_o), .tmr_out(tmr_out), .cfg_err(cfg_err)
  );

  // ---------------- behavioural reference model ----------------
  int m_mode, m_evsel, m_run, m_per, m_duty, m_cnt, m_cap, m_tgl, m_act, m_err;
  int n_cnt, n_cap, n_tgl, n_act, src, estep, trig;
  bit evh[$] = '{1'b0, 1'b0, 1'b0};

  function automatic int model_out();
    if (!m_run) return 0;
    case (m_mode)
      0, 1, 5, 6: return m_tgl;
      2, 3:       return (m_act != 0 && m_cnt < m_duty) ? 1 : 0;
      4:          return (m_cnt < m_duty) ? 1 : 0;
      default:    return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_evsel = 0; m_run = 0; m_per = 'hFFFF; m_duty = 0;
      m_cnt = 0; m_cap = 0; m_tgl = 0; m_act = 0; m_err = 0;
      evh = '{1'b0, 1'b0, 1'b0};
    end else begin
      estep = (evh[1] && !evh[2]) ? 1 : 0;
      trig  = (wr_en && wr_addr == 0 && wr_data[6] && m_run != 0 && (m_mode == 2 || m_mode == 3)) ? 1 : 0;
      if (m_mode == 6)                     src = tick_in;
      else if (m_mode == 1 || m_evsel != 0) src = estep;
      else                                  src = tick_in;
      n_cnt = m_cnt; n_cap = m_cap; n_tgl = m_tgl; n_act = m_act;
      if (m_run == 0 || m_mode == 7) begin
        n_cnt = 0; n_tgl = 0; n_act = 0;
      end else if (m_mode <= 1) begin
        if (src != 0) begin
          if (m_cnt >= m_per) begin n_cnt = 0; n_tgl = 1 - m_tgl; end
          else n_cnt = m_cnt + 1;
        end
      end else if (m_mode <= 3) begin
        if (trig != 0) begin n_act = 1; n_cnt = 0; end
        else if (m_act != 0 && src != 0) begin
          if (m_cnt >= m_per) begin n_cnt = 0; if (m_mode == 3) n_act = 0; end
          else n_cnt = m_cnt + 1;
        end
      end else if (m_mode == 4) begin
        if (src != 0) n_cnt = (m_cnt >= m_per) ? 0 : m_cnt + 1;
      end else if (m_mode == 5) begin
        if (src != 0) begin
          if (m_cnt == 'hFFFF) n_tgl = 1 - m_tgl;
          n_cnt = (m_cnt + 1) % 65536;
        end
      end else begin
        if (estep != 0) begin n_cap = m_cap == m_cap ? m_cnt : 0; n_cnt = 0; n_tgl = 1 - m_tgl; end
        else if (tick_in) n_cnt = (m_cnt + 1) % 65536;
      end
      if (wr_en) begin
        if (wr_addr == 0) begin
          if (m_run == 0 || (wr_data[2:0] == m_mode && wr_data[5] == m_evsel)) begin
            m_mode = wr_data[2:0]; m_evsel = wr_data[5];
          end else m_err = 1;
        end else if (wr_addr == 1) m_run = wr_data[0];
        else if (wr_addr == 2) m_per = wr_data;
        else m_duty = wr_data;
      end
      m_cnt = n_cnt; m_cap = n_cap; m_tgl = n_tgl; m_act = n_act;
      evh.push_front(evt_in);
      void'(evh.pop_back());
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "ctrl_rd",   ctrl_rd,   (m_evsel << 5) | m_mode);
      check(cur_req, "run_o",     run_o,     m_run);
      check(cur_req, "count_o",   count_o,   m_cnt);
      check(cur_req, "capture_o", capture_o, m_cap);
      check(cur_req, "tmr_out",   tmr_out,   model_out());
      check(cur_req, "cfg_err",   cfg_err,   m_err);
    end
  end

  always @(negedge clk) begin
    tcnt++;
    tick_in <= ((tcnt % tick_div) == 0);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_evt(input int hi, input int lo);
    evt_in = 1'b1; idle(hi);
    evt_in = 1'b0; idle(lo);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL all: watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int hi, prev, tg;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; evt_in = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    cur_req = "R1";
    check("R1", "reset ctrl_rd", ctrl_rd, 0);
    check("R1", "reset count", count_o, 0);
    check("R1", "reset out/err/run", {tmr_out, cfg_err, run_o}, 0);
    check("R1", "reset capture", capture_o, 0);

    cur_req = "R2";
    wr(0, 16'h00FF);
    check("R2", "reserved bits read 0", ctrl_rd, 'h27);

    cur_req = "R5";
    wr(0, 16'h0000); wr(2, 16'd3); wr(1, 16'd1);
    idle(3);
    tg = 0; prev = tmr_out;
    for (int i = 0; i < 16; i++) begin
      idle(1);
      if (tmr_out != prev) tg++;
      prev = tmr_out;
    end
    check("R5", "toggles in 16 clocks, period 3", tg, 4);

    cur_req = "R3";
    wr(0, 16'h0000);
    check("R3", "same-value write no error", cfg_err, 0);
    wr(0, 16'h0024);
    check("R3", "locked write sets error", cfg_err, 1);
    check("R3", "locked write ignored", ctrl_rd, 0);
    idle(2);
    check("R3", "error sticky", cfg_err, 1);

    cur_req = "R8";
    wr(0, 16'h0040);
    check("R8", "trigger in interval mode", ctrl_rd, 0);
    idle(4);

    cur_req = "R12";
    wr(1, 16'd0);
    idle(2);
    check("R12", "stopped count", count_o, 0);
    check("R12", "stopped out", tmr_out, 0);

    cur_req = "R4";
    wr(2, 16'd100); wr(0, 16'h0020); wr(1, 16'd1);
    idle(6);
    check("R4", "no events, no count", count_o, 0);
    for (int i = 0; i < 5; i++) pulse_evt(3, 4);
    idle(4);
    check("R4", "count follows event edges", count_o, 5);
    wr(1, 16'd0); wr(0, 16'h0001); wr(1, 16'd1);
    for (int i = 0; i < 3; i++) pulse_evt(2, 5);
    idle(4);
    check("R4", "event mode forces external source", count_o, 3);

    cur_req = "R6";
    wr(1, 16'd0); wr(2, 16'd7); wr(3, 16'd3); wr(0, 16'h0004); wr(1, 16'd1);
    idle(3);
    hi = 0;
    for (int i = 0; i < 16; i++) begin hi += tmr_out; idle(1); end
    check("R6", "PWM high clocks in 16", hi, 6);

    cur_req = "R7";
    wr(1, 16'd0); wr(2, 16'd5); wr(3, 16'd2); wr(0, 16'h0003); wr(1, 16'd1);
    idle(5);
    check("R8", "one-shot waits for trigger", count_o, 0);
    wr(0, 16'h0043);
    hi = 0;
    for (int i = 0; i < 10; i++) begin hi += tmr_out; idle(1); end
    check("R7", "one-shot pulse length", hi, 2);
    check("R7", "one-shot rests at 0", count_o, 0);

    wr(1, 16'd0); wr(2, 16'd3); wr(3, 16'd1); wr(0, 16'h0002); wr(1, 16'd1);
    idle(4);
    check("R8", "triggered PWM idle before trigger", count_o, 0);
    wr(0, 16'h0042);
    hi = 0;
    for (int i = 0; i < 12; i++) begin hi += tmr_out; idle(1); end
    check("R7", "triggered PWM high clocks", hi, 3);
    idle(1);
    wr(0, 16'h0042);
    check("R7", "retrigger restarts at 0", count_o, 0);

    cur_req = "R8";
    wr(1, 16'd0); wr(0, 16'h0043); wr(1, 16'd1);
    idle(5);
    check("R8", "trigger while stopped ignored", count_o, 0);
    check("R8", "no pulse after stopped trigger", tmr_out, 0);

    cur_req = "R9";
    wr(1, 16'd0); wr(0, 16'h0005); wr(1, 16'd1);
    idle(65540);
    check("R9", "free-run wrapped count", count_o, 4);
    check("R9", "free-run wrap toggles", tmr_out, 1);

    cur_req = "R10";
    wr(1, 16'd0); wr(0, 16'h0006); wr(1, 16'd1);
    for (int i = 0; i < 3; i++) pulse_evt(2, 18);
    idle(4);
    check("R10", "captured width", capture_o, 19);

    cur_req = "R11";
    wr(1, 16'd0); wr(0, 16'h0007); wr(1, 16'd1);
    idle(5);
    check("R11", "prohibited mode count", count_o, 0);
    check("R11", "prohibited mode out", tmr_out, 0);

    summary();
    $finish;
  end

endmodule